// File: doc/BRIEF.md
# Security-Aware System Control Space Decoder

This block sits between a processor's private peripheral bus master and the handful of register blocks that live in the 1 MB system control region at 0xE000_0000. Each request carries an address, a direction, a byte count, a secure attribute and an unprivileged attribute. The decoder works out which register block owns the address and drives that block's one-hot select, the 12-bit window offset and the security attribute the block should see. One clock later it returns the owner's read data and error flag, or a computed default response if no block owns the address.

There are four targets: the system control register block, two banks of tick-timer registers (one for each security state), and an optional error-record block. Windows overlap, and they resolve by fixed priority. The tick-timer window beats the system control window, which beats the error-record window, which beats the default response. When the security extension is built in, a second 4 KB window repeats the system control layout. A secure request that lands there reaches the main targets as if it were non-secure. A non-secure request that lands there gets only the default treatment. Two elaboration parameters remove the security extension and the error-record block, and each removed window then falls through to the default response.

Top module: `ppb_secure_decoder`

## Requirements
- R1: A valid request whose address lies outside 0xE000_0000..0xE00F_FFFF selects no target (tgt_sel = 0). On the next cycle it responds with rsp_err = 1 and rsp_rdata = 0.
- R2: A valid request inside the region that no window claims selects no target, so a write to it changes nothing. If privileged with a legal size, it responds with zero data and rsp_err = 0. If unprivileged (req_user = 1), it responds with rsp_err = 1.
- R3: req_size is a byte count. Counts 1 to 8 are legal for the default response. A count of 0 or above 8 makes a default response an error even for a privileged request.
- R4: Addresses 0xE000_E000..0xE000_EFFF select the system control block (tgt_sel = 4'b0001), with tgt_offset = address bits [11:0].
- R5: Addresses 0xE000_E010..0xE000_E0EF select a tick-timer bank in preference to the system control block. 0xE000_E00C and 0xE000_E0F0 still select the system control block.
- R6: A tick-timer hit selects the secure bank (tgt_sel = 4'b0100) when the forwarded secure attribute is 1 and the security extension is built in. Otherwise it selects the non-secure bank (4'b0010).
- R7: With the error-record block built in, 0xE000_5000..0xE000_5FFF selects it (tgt_sel = 4'b1000). Without it, that range gets the default response.
- R8: With the security extension, a secure request to 0xE002_E000..0xE002_EFFF is decoded as the same offset in the system control window (its tick sub-window included), and is forwarded with tgt_secure = 0.
- R9: A non-secure request to the alias window selects no target. If privileged it reads zero with no error, whatever its size. If unprivileged it returns rsp_err = 1. Without the security extension, the whole alias window gets the default response.
- R10: While a target is selected, tgt_write, tgt_wdata and tgt_size equal the request's fields, and tgt_secure equals req_secure outside the alias window. tgt_sel is 0 whenever req_valid is 0.
- R11: rsp_valid follows req_valid one cycle later. A read of a target returns that target's read data and error flag. A write returns zero data together with the target's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| req_user | input | 1 | Unprivileged attribute of the request |
| tgt_sel | output | 4 | One-hot target select: bit0 system control, bit1 non-secure timer, bit2 secure timer, bit3 error record |
| tgt_offset | output | 12 | Offset within the 4 KB window |
| tgt_write | output | 1 | Forwarded direction |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_size | output | 4 | Forwarded size |
| tgt_secure | output | 1 | Secure attribute the target should use |
| tgt_rdata | input | 128 | Read data of the four targets, target n in bits [32n+31:32n] |
| tgt_err | input | 4 | Error flag of each target, bit n for target n |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Response bus error |

## Verification
The assertions assume that each target returns its read data and error flag in the same cycle it is selected, and that request fields are stable for the whole cycle in which req_valid is high. The bench's target models are constant per-target data words plus a driven error vector. All request fields change on the falling edge only. The bench also drives a second instance with the security extension and the error-record block removed. The same requests are sent to both instances, so every fall-through case is checked against the full build.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  localparam int unsigned NUM_TGT     = 4;
  localparam int unsigned TGT_SCB     = 0;
  localparam int unsigned TGT_TICK_NS = 1;
  localparam int unsigned TGT_TICK_S  = 2;
  localparam int unsigned TGT_EREC    = 3;

  typedef enum logic [2:0] {
    RT_IDLE,
    RT_TARGET,
    RT_DEFAULT,
    RT_ALIAS_NS,
    RT_OUTSIDE
  } route_e;

  // Half-open window test: base <= a < base + len, written without overflow.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] len);
    return (a >= base) && ((a - base) < len);
  endfunction

  // Byte counts accepted by the default responder.
  function automatic logic size_legal(input logic [3:0] bytes);
    return (bytes >= 4'd1) && (bytes <= 4'd8);
  endfunction

endpackage

// File: rtl/ppb_window_decode.sv
module ppb_window_decode
  import ppb_pkg::*;
#(
  parameter logic [31:0] REGION_BASE = 32'hE000_0000,
  parameter logic [31:0] REGION_LEN  = 32'h0010_0000,
  parameter logic [31:0] SCB_BASE    = 32'hE000_E000,
  parameter logic [31:0] ALIAS_BASE  = 32'hE002_E000,
  parameter logic [31:0] EREC_BASE   = 32'hE000_5000,
  parameter logic [31:0] WIN_LEN     = 32'h0000_1000,
  parameter logic [31:0] TICK_OFS    = 32'h0000_0010,
  parameter logic [31:0] TICK_LEN    = 32'h0000_00E0,
  parameter bit          HAS_SEC     = 1'b1,
  parameter bit          HAS_EREC    = 1'b1,
  localparam int unsigned OFS_W      = $clog2(WIN_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [31:0]        addr,
  input  logic               secure,
  output route_e             route,
  output logic [NUM_TGT-1:0] sel,
  output logic               fwd_secure,
  output logic [OFS_W-1:0]   offset
);

  logic in_region, alias_hit, alias_fwd, scb_like, tick_hit, erec_hit;

  assign offset     = addr[OFS_W-1:0];
  assign in_region  = in_window(addr, REGION_BASE, REGION_LEN);
  assign alias_hit  = HAS_SEC && in_window(addr, ALIAS_BASE, WIN_LEN);
  assign alias_fwd  = alias_hit && secure;
  assign scb_like   = in_window(addr, SCB_BASE, WIN_LEN) || alias_fwd;
  assign tick_hit   = scb_like &&
                      in_window({{(32-OFS_W){1'b0}}, offset}, TICK_OFS, TICK_LEN);
  assign erec_hit   = HAS_EREC && in_window(addr, EREC_BASE, WIN_LEN);
  assign fwd_secure = secure && !alias_hit;

  always_comb begin
    sel   = '0;
    route = RT_IDLE;
    if (valid) begin
      if (!in_region) begin
        route = RT_OUTSIDE;
      end else if (alias_hit && !secure) begin
        route = RT_ALIAS_NS;
      end else if (tick_hit) begin
        route = RT_TARGET;
        if (HAS_SEC && fwd_secure) sel[TGT_TICK_S]  = 1'b1;
        else                       sel[TGT_TICK_NS] = 1'b1;
      end else if (scb_like) begin
        route = RT_TARGET;
        sel[TGT_SCB] = 1'b1;
      end else if (erec_hit) begin
        route = RT_TARGET;
        sel[TGT_EREC] = 1'b1;
      end else begin
        route = RT_DEFAULT;
      end
    end
  end

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_idle_no_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (sel == '0));

  assert_secure_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel[TGT_TICK_S] |-> (secure && fwd_secure));

  assert_alias_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && alias_fwd) |-> (!fwd_secure && !sel[TGT_TICK_S] && (sel != '0)));

  assert_outside_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_OUTSIDE) |-> (sel == '0));

endmodule

// File: rtl/ppb_default_resp.sv
module ppb_default_resp
  import ppb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   user,
  input  logic [3:0] size,
  output logic   def_err
);

  logic size_ok;
  assign size_ok = size_legal(size);

  always_comb begin
    unique case (route)
      RT_OUTSIDE:  def_err = 1'b1;
      RT_DEFAULT:  def_err = user || !size_ok;
      RT_ALIAS_NS: def_err = user;
      default:     def_err = 1'b0;
    endcase
  end

  assert_priv_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_DEFAULT && !user && size >= 4'd1 && size <= 4'd8) |-> !def_err);

  assert_user_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((route == RT_DEFAULT || route == RT_ALIAS_NS) && user) |-> def_err);

endmodule

// File: rtl/ppb_resp_reg.sv
module ppb_resp_reg
  import ppb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid,
  input  logic                      write,
  input  logic [NUM_TGT-1:0]        sel,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  input  logic [NUM_TGT-1:0]        tgt_err,
  input  logic                      def_err,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err
);

  logic [DATA_W-1:0]  masked [NUM_TGT];
  logic [NUM_TGT-1:0] err_hit;
  logic [DATA_W-1:0]  mux_data, next_data;
  logic               next_err;

  for (genvar gi = 0; gi < NUM_TGT; gi++) begin : g_pick
    assign masked[gi]  = sel[gi] ? tgt_rdata[gi*DATA_W +: DATA_W] : '0;
    assign err_hit[gi] = sel[gi] & tgt_err[gi];
  end

  always_comb begin
    mux_data = '0;
    for (int i = 0; i < NUM_TGT; i++) mux_data = mux_data | masked[i];
  end

  assign next_data = write ? '0 : mux_data;
  assign next_err  = (|err_hit) | def_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid;
      rsp_rdata <= valid ? next_data : '0;
      rsp_err   <= valid ? next_err : 1'b0;
    end
  end

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> rsp_valid);

  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!rsp_valid && !rsp_err));

  assert_write_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write) |=> (rsp_rdata == '0));

  assert_unclaimed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sel == '0) |=> (rsp_rdata == '0));

endmodule

// File: rtl/ppb_secure_decoder.sv
module ppb_secure_decoder
  import ppb_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter bit          HAS_SEC  = 1'b1,
  parameter bit          HAS_EREC = 1'b1,
  localparam int unsigned OFS_W   = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [31:0]               req_addr,
  input  logic                      req_write,
  input  logic [3:0]                req_size,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      req_secure,
  input  logic                      req_user,
  output logic [NUM_TGT-1:0]        tgt_sel,
  output logic [OFS_W-1:0]          tgt_offset,
  output logic                      tgt_write,
  output logic [DATA_W-1:0]         tgt_wdata,
  output logic [3:0]                tgt_size,
  output logic                      tgt_secure,
  input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
  input  logic [NUM_TGT-1:0]        tgt_err,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err
);

  route_e route;
  logic   def_err;

  assign tgt_write = req_write;
  assign tgt_wdata = req_wdata;
  assign tgt_size  = req_size;

  ppb_window_decode #(
    .HAS_SEC  (HAS_SEC),
    .HAS_EREC (HAS_EREC)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (req_valid),
    .addr       (req_addr),
    .secure     (req_secure),
    .route      (route),
    .sel        (tgt_sel),
    .fwd_secure (tgt_secure),
    .offset     (tgt_offset)
  );

  ppb_default_resp u_default (
    .clk     (clk),
    .rst_n   (rst_n),
    .route   (route),
    .user    (req_user),
    .size    (req_size),
    .def_err (def_err)
  );

  ppb_resp_reg #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (req_valid),
    .write     (req_write),
    .sel       (tgt_sel),
    .tgt_rdata (tgt_rdata),
    .tgt_err   (tgt_err),
    .def_err   (def_err),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

endmodule

// File: tb/ppb_secure_decoder_bench.sv
module ppb_secure_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_size = 4'd4;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0;
  logic        req_user = 1'b0;
  logic [3:0]  terr = 4'b0000;
  logic [127:0] trdata = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};

  logic [3:0]  f_sel, l_sel;
  logic [11:0] f_ofs, l_ofs;
  logic        f_wr, l_wr, f_sec, l_sec, f_rv, l_rv, f_re, l_re;
  logic [31:0] f_wd, l_wd, f_rd, l_rd;
  logic [3:0]  f_sz, l_sz;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppb_secure_decoder u_ppb_secure_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user),
    .tgt_sel(f_sel), .tgt_offset(f_ofs), .tgt_write(f_wr), .tgt_wdata(f_wd),
    .tgt_size(f_sz), .tgt_secure(f_sec), .tgt_rdata(trdata), .tgt_err(terr),
    .rsp_valid(f_rv), .rsp_rdata(f_rd), .rsp_err(f_re));

  ppb_secure_decoder #(.HAS_SEC(1'b0), .HAS_EREC(1'b0)) u_ppb_secure_decoder_lite (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .req_secure(req_secure), .req_user(req_user),
    .tgt_sel(l_sel), .tgt_offset(l_ofs), .tgt_write(l_wr), .tgt_wdata(l_wd),
    .tgt_size(l_sz), .tgt_secure(l_sec), .tgt_rdata(trdata), .tgt_err(terr),
    .rsp_valid(l_rv), .rsp_rdata(l_rd), .rsp_err(l_re));

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: which target (-1 = none), the secure flag seen by
  // the target, and the error of the default response.
  task automatic ref_model(input bit has_sec, input bit has_erec,
                           input longint a, input bit sec, input bit usr,
                           input int sz, output int tgt, output bit fsec,
                           output bit derr);
    bit alias_w, scb_w;
    longint o;
    tgt = -1; fsec = sec; derr = 0;
    alias_w = has_sec && a >= 64'hE002_E000 && a < 64'hE002_F000;
    if (alias_w) fsec = 0;
    if (a < 64'hE000_0000 || a >= 64'hE010_0000) begin
      derr = 1;
    end else if (alias_w && !sec) begin
      derr = usr;
    end else begin
      scb_w = alias_w || (a >= 64'hE000_E000 && a < 64'hE000_F000);
      o = alias_w ? a - 64'hE002_E000 : a - 64'hE000_E000;
      if (scb_w && o >= 16 && o < 240)        tgt = (has_sec && fsec) ? 2 : 1;
      else if (scb_w)                          tgt = 0;
      else if (has_erec && a >= 64'hE000_5000 && a < 64'hE000_6000) tgt = 3;
      else derr = usr || sz < 1 || sz > 8;
    end
  endtask

  task automatic do_req(input logic [31:0] a, input bit wr, input int sz,
                        input bit sec, input bit usr, input string tag);
    int t_f, t_l;
    bit s_f, s_l, e_f, e_l;
    logic [3:0] x_f, x_l;
    longint rd_f, rd_l, er_f, er_l;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_size = sz[3:0];
    req_wdata = a ^ 32'h5A5A_1234; req_secure = sec; req_user = usr;
    ref_model(1'b1, 1'b1, a, sec, usr, sz, t_f, s_f, e_f);
    ref_model(1'b0, 1'b0, a, sec, usr, sz, t_l, s_l, e_l);
    x_f = (t_f < 0) ? 4'b0 : 4'(1 << t_f);
    x_l = (t_l < 0) ? 4'b0 : 4'(1 << t_l);
    #1;
    check(tag, "full tgt_sel", f_sel, x_f);
    check(tag, "lite tgt_sel", l_sel, x_l);
    if (t_f >= 0) begin
      check(tag, "offset",     f_ofs, a[11:0]);
      check(tag, "tgt_secure", f_sec, s_f);
      check("R10", "forwarded fields", {f_wr, f_sz, f_wd},
            {wr, sz[3:0], a ^ 32'h5A5A_1234});
    end
    rd_f = (t_f < 0 || wr) ? 0 : trdata[t_f*32 +: 32];
    rd_l = (t_l < 0 || wr) ? 0 : trdata[t_l*32 +: 32];
    er_f = (t_f < 0) ? e_f : terr[t_f];
    er_l = (t_l < 0) ? e_l : terr[t_l];
    @(posedge clk); #1;
    check(tag, "full rsp {valid,err,data}", {f_rv, f_re, f_rd}, {1'b1, er_f[0], rd_f[31:0]});
    check(tag, "lite rsp {valid,err,data}", {l_rv, l_re, l_rd}, {1'b1, er_l[0], rd_l[31:0]});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = 0; req_addr = 32'hE000_E010;
    #1 check("R10", "idle tgt_sel", {f_sel, l_sel}, 0);
    @(posedge clk); #1;
    check("R11", "idle rsp", {f_rv, f_re, l_rv, l_re}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11", "reset rsp", {f_rv, f_re, f_rd}, 0);
    @(negedge clk) rst_n = 1;
    // R4 system control window
    do_req(32'hE000_E100, 0, 4, 0, 0, "R4");
    do_req(32'hE000_EFFC, 1, 4, 1, 0, "R4");
    // R5 timer priority and its edges
    do_req(32'hE000_E010, 0, 4, 0, 0, "R5");
    do_req(32'hE000_E0EC, 0, 4, 0, 1, "R5");
    do_req(32'hE000_E0F0, 0, 4, 0, 0, "R5");
    do_req(32'hE000_E00C, 0, 4, 0, 0, "R5");
    // R6 bank choice
    do_req(32'hE000_E018, 0, 4, 1, 0, "R6");
    do_req(32'hE000_E018, 1, 4, 0, 0, "R6");
    // R7 error-record window
    do_req(32'hE000_5004, 0, 4, 0, 0, "R7");
    do_req(32'hE000_5FFC, 0, 4, 1, 1, "R7");
    // R8 secure alias
    do_req(32'hE002_E020, 0, 4, 1, 0, "R8");
    do_req(32'hE002_E400, 0, 4, 1, 0, "R8");
    // R9 non-secure alias
    do_req(32'hE002_E400, 0, 4, 0, 0, "R9");
    do_req(32'hE002_E020, 1, 0, 0, 0, "R9");
    do_req(32'hE002_E020, 0, 4, 0, 1, "R9");
    // R2 unclaimed space
    do_req(32'hE000_1000, 0, 4, 0, 0, "R2");
    do_req(32'hE000_1000, 1, 4, 1, 0, "R2");
    do_req(32'hE00F_FFFC, 0, 4, 0, 1, "R2");
    // R3 sizes
    do_req(32'hE000_2000, 0, 0, 0, 0, "R3");
    do_req(32'hE000_2000, 0, 9, 0, 0, "R3");
    do_req(32'hE000_2000, 0, 8, 0, 0, "R3");
    do_req(32'hE000_2000, 1, 1, 0, 0, "R3");
    // R1 outside the region
    do_req(32'hE010_0000, 0, 4, 0, 0, "R1");
    do_req(32'hDFFF_FFFC, 0, 4, 1, 0, "R1");
    // R11 target error propagation, writes, idle
    terr = 4'b0101;
    do_req(32'hE000_E200, 0, 4, 0, 0, "R11");
    do_req(32'hE000_E020, 1, 4, 1, 0, "R11");
    do_req(32'hE000_E020, 0, 4, 0, 0, "R11");
    terr = 4'b0000;
    idle_cycle();
    do_req(32'hE000_E300, 0, 2, 0, 0, "R11");
    idle_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule